// File: doc/BRIEF.md
# Sleep-Gated Dual-Rail Pipeline Stage

This block is one stage of a delay-insensitive dual-rail pipeline. Here the NULL spacer between data wavefronts is not carried through the logic. A sleep signal forces every gate output low instead. Each data bit travels on two rails, a true rail and a false rail. Exactly one rail high is a DATA value. Both rails low is NULL. Both rails high is illegal. The stage holds an input register, an early completion detector and a combinational function, and all three run on one clock.

The completion detector looks at the register inputs, not at the register outputs. It changes its request only when a whole wavefront has arrived and the downstream stage asks for that kind of wavefront. Its request output `ko` is the sleep signal for two things: this stage's register and the combinational function that follows it. The same signal goes upstream as this stage's request. It also goes downstream, where it sleeps the next stage's completion logic. The `sleep_in` input is the matching signal from the stage before. It forces the inputs this stage sees to NULL.

Each register rail is a sleep-capable 1-of-2 gate with its output fed back to one of its inputs. Once the register is awake, it keeps any rail that went high until sleep clears it. The function after the register is chosen by a parameter: buffer, dual-rail AND or dual-rail XOR.

Top module: `mtncl_stage`

## Requirements
- R1: After reset, `ko` is 1 (request DATA, stage asleep) and every rail of `out_t` and `out_f` is 0.
- R2: The stage wakes only at an active edge where all three of these hold: every input bit has exactly one rail high, `ki` is 1 and `sleep_in` is 0. From that edge on, `ko` reads 0.
- R3: If any input bit is NULL, the stage does not wake, and its outputs stay all-zero.
- R4: An input bit with both rails high does not count as DATA, so it cannot wake the stage.
- R5: While `ki` is 0, a complete DATA wavefront does not wake the stage.
- R6: The register captures the input wavefront at the wake edge. In the cycle where `ko` first reads 0, the output already shows the function of that wavefront. An output bit with value 1 is `out_t`=1, `out_f`=0. A bit with value 0 is `out_t`=0, `out_f`=1.
- R7: While the stage is awake, the register and the outputs keep the captured value after the inputs return to NULL.
- R8: An awake stage goes back to sleep (`ko` to 1) only at an edge where every visible input is NULL and `ki` is 0. DATA inputs with `ki`=0 keep it awake. NULL inputs with `ki`=1 also keep it awake.
- R9: Whenever `ko` is 1, the register rails and every output rail are 0.
- R10: While `sleep_in` is 1, the stage sees its inputs as NULL. It cannot wake, and with `ki`=0 an awake stage goes to sleep even if DATA is present.
- R11: The output is never a partial wavefront. In each cycle, either every output bit is DATA or every output rail is 0.
- R12: Output bit i is computed from register bits i and (i+1) mod WIDTH. With FUNC=0 the output is bit i unchanged. With FUNC=1 it is bit i AND bit (i+1) mod WIDTH. With FUNC=2 it is bit i XOR bit (i+1) mod WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_in | input | 1 | Sleep from the upstream stage; forces the visible inputs to NULL |
| in_t | input | WIDTH | True rails of the incoming wavefront |
| in_f | input | WIDTH | False rails of the incoming wavefront |
| ki | input | 1 | Downstream request: 1 asks for DATA, 0 asks for NULL |
| ko | output | 1 | This stage's request and sleep: 1 means asleep and asking for DATA |
| out_t | output | WIDTH | True rails of the function output |
| out_f | output | WIDTH | False rails of the function output |

## Verification
The assertions check the following on every cycle:
- the register is empty whenever `ko` is high;
- the output is always a whole wavefront or all-zero;
- a wake edge was preceded by a complete, legal DATA wavefront with `ki` high and `sleep_in` low;
- a sleep edge was preceded by `ki` low;
- an awake register never drops a rail;
- `sleep_in` never lets the stage wake.

Some behaviour only the bench scenarios can show. These are the actual function values for every 4-bit input under all three function variants, and that partial and illegal inputs stall the stage. They also include the exact cycle in which the output appears and clears, and the cases where DATA held with `ki` low, or NULL held with `ki` high, keeps the stage awake.

// File: rtl/mtncl_pkg.sv
`timescale 1ns/1ps
package mtncl_pkg;
    // Function selector values for the combinational block.
    localparam int FN_BUF = 0;
    localparam int FN_AND = 1;
    localparam int FN_XOR = 2;
endpackage

// File: rtl/mtncl_early_comp.sv
`timescale 1ns/1ps
module mtncl_early_comp #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_in,
    input  logic [WIDTH-1:0] in_t,
    input  logic [WIDTH-1:0] in_f,
    input  logic             ki,
    output logic [WIDTH-1:0] vis_t,
    output logic [WIDTH-1:0] vis_f,
    output logic             wake_next,
    output logic             ko
);
    typedef struct packed {
        logic done;
    } comp_state_t;

    comp_state_t st_d, st_q;
    logic        all_data;
    logic        all_null;

    always_comb begin
        // Upstream sleep forces the gates feeding this detector low.
        vis_t    = sleep_in ? '0 : in_t;
        vis_f    = sleep_in ? '0 : in_f;
        all_data = &(vis_t ^ vis_f);
        all_null = ~|(vis_t | vis_f);
        st_d     = st_q;
        if (!st_q.done && all_data && ki)
            st_d.done = 1'b1;
        else if (st_q.done && all_null && !ki)
            st_d.done = 1'b0;
        wake_next = st_d.done;
        ko        = ~st_q.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    AST_SLEEPIN_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_in && ko) |=> ko); // R10
endmodule

// File: rtl/mtncl_sleep_reg.sv
`timescale 1ns/1ps
module mtncl_sleep_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_next,
    input  logic [WIDTH-1:0] d_t,
    input  logic [WIDTH-1:0] d_f,
    output logic [WIDTH-1:0] q_t,
    output logic [WIDTH-1:0] q_f
);
    typedef struct packed {
        logic [WIDTH-1:0] t;
        logic [WIDTH-1:0] f;
    } rail_state_t;

    rail_state_t rg_d, rg_q;

    // Each rail: 1-of-2 gate, one input is its own output; sleep clears it.
    always_comb begin
        rg_d = '0;
        for (int i = 0; i < WIDTH; i++) begin
            rg_d.t[i] = wake_next & (rg_q.t[i] | d_t[i]);
            rg_d.f[i] = wake_next & (rg_q.f[i] | d_f[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rg_q <= '0;
        else
            rg_q <= rg_d;
    end

    assign q_t = rg_q.t;
    assign q_f = rg_q.f;
endmodule

// File: rtl/mtncl_comb.sv
`timescale 1ns/1ps
module mtncl_comb
    import mtncl_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int FUNC  = FN_AND
) (
    input  logic             sleep,
    input  logic [WIDTH-1:0] a_t,
    input  logic [WIDTH-1:0] a_f,
    output logic [WIDTH-1:0] y_t,
    output logic [WIDTH-1:0] y_f
);
    logic [WIDTH-1:0] raw_t, raw_f;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int NB = (i + 1) % WIDTH;
        if (FUNC == FN_BUF) begin : g_buf
            assign raw_t[i] = a_t[i];
            assign raw_f[i] = a_f[i];
        end else if (FUNC == FN_AND) begin : g_and
            assign raw_t[i] = a_t[i] & a_t[NB];
            assign raw_f[i] = a_f[i] | a_f[NB];
        end else begin : g_xor
            assign raw_t[i] = (a_t[i] & a_f[NB]) | (a_f[i] & a_t[NB]);
            assign raw_f[i] = (a_t[i] & a_t[NB]) | (a_f[i] & a_f[NB]);
        end
    end

    // Sleep pulls every gate output low.
    always_comb begin
        y_t = sleep ? '0 : raw_t;
        y_f = sleep ? '0 : raw_f;
    end
endmodule

// File: rtl/mtncl_stage.sv
`timescale 1ns/1ps
module mtncl_stage
    import mtncl_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int FUNC  = FN_AND
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_in,
    input  logic [WIDTH-1:0] in_t,
    input  logic [WIDTH-1:0] in_f,
    input  logic             ki,
    output logic             ko,
    output logic [WIDTH-1:0] out_t,
    output logic [WIDTH-1:0] out_f
);
    logic [WIDTH-1:0] vis_t, vis_f;
    logic [WIDTH-1:0] reg_t, reg_f;
    logic             wake_next;

    mtncl_early_comp #(.WIDTH(WIDTH)) u_comp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_in  (sleep_in),
        .in_t      (in_t),
        .in_f      (in_f),
        .ki        (ki),
        .vis_t     (vis_t),
        .vis_f     (vis_f),
        .wake_next (wake_next),
        .ko        (ko)
    );

    mtncl_sleep_reg #(.WIDTH(WIDTH)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_next (wake_next),
        .d_t       (vis_t),
        .d_f       (vis_f),
        .q_t       (reg_t),
        .q_f       (reg_f)
    );

    mtncl_comb #(.WIDTH(WIDTH), .FUNC(FUNC)) u_comb (
        .sleep (ko),
        .a_t   (reg_t),
        .a_f   (reg_f),
        .y_t   (out_t),
        .y_f   (out_f)
    );

    AST_SLEEP_EMPTY_REG: assert property (@(posedge clk) disable iff (!rst_n)
        ko |-> ((reg_t | reg_f) == '0)); // R9
    AST_WHOLE_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (((out_t | out_f) == '0) || ((out_t ^ out_f) == '1))); // R11
    AST_WAKE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ko) |-> ($past(ki) && !$past(sleep_in) && ($past(in_t ^ in_f) == '1)
                       && ($past(in_t & in_f) == '0))); // R2
    AST_SLEEP_NEEDS_KI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ko) |-> !$past(ki)); // R8
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ko && !$past(ko)) |-> (((reg_t & $past(reg_t)) == $past(reg_t))
                                 && ((reg_f & $past(reg_f)) == $past(reg_f)))); // R7
endmodule

// File: tb/test_mtncl_stage.sv
`timescale 1ns/1ps
module test_mtncl_stage;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         sleep_in;
    logic         ki;
    logic [W-1:0] in_t, in_f;

    logic         ko_and, ko_buf, ko_xor;
    logic [W-1:0] ot_and, of_and, ot_buf, of_buf, ot_xor, of_xor;

    int n_cmp  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mtncl_stage #(.WIDTH(W), .FUNC(1)) i_mtncl_stage (
        .clk(clk), .rst_n(rst_n), .sleep_in(sleep_in), .in_t(in_t), .in_f(in_f),
        .ki(ki), .ko(ko_and), .out_t(ot_and), .out_f(of_and));
    mtncl_stage #(.WIDTH(W), .FUNC(0)) i_mtncl_stage_buf (
        .clk(clk), .rst_n(rst_n), .sleep_in(sleep_in), .in_t(in_t), .in_f(in_f),
        .ki(ki), .ko(ko_buf), .out_t(ot_buf), .out_f(of_buf));
    mtncl_stage #(.WIDTH(W), .FUNC(2)) i_mtncl_stage_xor (
        .clk(clk), .rst_n(rst_n), .sleep_in(sleep_in), .in_t(in_t), .in_f(in_f),
        .ki(ki), .ko(ko_xor), .out_t(ot_xor), .out_f(of_xor));

    function automatic logic [W-1:0] fexp(int fn, logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            if (fn == 0)      r[i] = v[i];
            else if (fn == 1) r[i] = v[i] & v[(i + 1) % W];
            else              r[i] = v[i] ^ v[(i + 1) % W];
        end
        return r;
    endfunction

    task automatic cmp(string req, string who, logic [2*W:0] act, logic [2*W:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, who, act, exp);
        end
    endtask

    // Compare {ko,out_t,out_f} of all three variants.
    task automatic check(string req, bit awake, logic [W-1:0] v);
        logic [W-1:0] e;
        e = fexp(1, v);
        cmp(req, "and", {ko_and, ot_and, of_and}, awake ? {1'b0, e, ~e} : {1'b1, {2*W{1'b0}}});
        e = fexp(0, v);
        cmp(req, "buf", {ko_buf, ot_buf, of_buf}, awake ? {1'b0, e, ~e} : {1'b1, {2*W{1'b0}}});
        e = fexp(2, v);
        cmp(req, "xor", {ko_xor, ot_xor, of_xor}, awake ? {1'b0, e, ~e} : {1'b1, {2*W{1'b0}}});
    endtask

    task automatic put(logic [W-1:0] v);
        in_t = v;
        in_f = ~v;
    endtask

    task automatic put_null();
        in_t = '0;
        in_f = '0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    endtask

    // Return an awake stage to sleep and request DATA again.
    task automatic drain();
        put_null();
        sleep_in = 1'b0;
        ki = 1'b0;
        tick();
        ki = 1'b1;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sleep_in = 1'b0;
        ki = 1'b1;
        put_null();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1", 1'b0, '0);

        // Full sweep: wake, hold, release (R2 R6 R12 R7 R8 R9)
        for (int v = 0; v < (1 << W); v++) begin
            put(v[W-1:0]);
            tick();
            check("R2_R6_R12", 1'b1, v[W-1:0]);
            put_null();
            tick();
            check("R7", 1'b1, v[W-1:0]);
            ki = 1'b0;
            tick();
            check("R8_R9", 1'b0, '0);
            ki = 1'b1;
            tick();
            check("R9", 1'b0, '0);
        end

        // Partial wavefronts stall (R3 R11)
        for (int k = 0; k < W; k++) begin
            put(4'b0101);
            in_t[k] = 1'b0;
            in_f[k] = 1'b0;
            tick();
            check("R3_R11", 1'b0, '0);
            tick();
            check("R3_R11", 1'b0, '0);
            put(4'b0101);
            tick();
            check("R2", 1'b1, 4'b0101);
            drain();
        end

        // Illegal code on one bit (R4)
        put(4'b1001);
        in_t[2] = 1'b1;
        in_f[2] = 1'b1;
        tick();
        check("R4", 1'b0, '0);
        tick();
        check("R4", 1'b0, '0);
        put_null();
        tick();

        // ki low blocks wake (R5), then DATA/NULL hold awake (R8)
        put(4'b0110);
        ki = 1'b0;
        tick();
        check("R5", 1'b0, '0);
        tick();
        check("R5", 1'b0, '0);
        ki = 1'b1;
        tick();
        check("R5", 1'b1, 4'b0110);
        ki = 1'b0;
        tick();
        check("R8", 1'b1, 4'b0110);
        put_null();
        ki = 1'b1;
        tick();
        check("R8", 1'b1, 4'b0110);
        ki = 1'b0;
        tick();
        check("R8", 1'b0, '0);
        ki = 1'b1;
        tick();

        // Upstream sleep (R10)
        sleep_in = 1'b1;
        put(4'b0011);
        tick();
        check("R10", 1'b0, '0);
        tick();
        check("R10", 1'b0, '0);
        sleep_in = 1'b0;
        tick();
        check("R10", 1'b1, 4'b0011);
        ki = 1'b0;
        sleep_in = 1'b1;
        tick();
        check("R10", 1'b0, '0);
        drain();
        check("R1_R9", 1'b0, '0);

        summary();
        $finish;
    end
endmodule